// File: doc/BRIEF.md
# Shared-Memory Bank Conflict Scheduler

This block turns one warp's shared-memory request into an issue plan. It takes the byte address of every lane and a mask of the lanes that are active. Lanes in the same warp part that ask for the same address become a single access. Each access then gets an issue order, which is the cycle slot where it may go to the banked array. Two accesses that use the same bank never share a slot, unless one of them is a broadcast that was given a slot of its own. The warp is split into parts of equal length. A part's accesses never start before that part's first lane index, so parts do not overlap in time.

After it has looked at all the lanes, the block streams out the access list over a valid/ready interface. The list is sorted by issue order, and accesses with the same order keep the order in which they were created. Every beat carries the access address, its order, the lanes it serves, a last flag and the number of distinct order values, which is the number of slots the instruction occupies. The banked memory is not part of this block.

Top module: `sbs_sched`

## Requirements
- R1: The bank of an address is (address / 4) mod 16, so address bits [5:2] with the default parameters. Byte offsets inside one word are still different addresses.
- R2: Active lanes of one part that carry the same address produce one access. Its `out_lanes` bit i is set for every lane i that it serves.
- R3: The warp is split into 2 parts of 16 lanes (lanes 0 to 15 and lanes 16 to 31). Lanes in different parts never share an access.
- R4: A new access takes its bank's counter as its order, and the counter then increments. All 16 counters are cleared when an instruction is accepted.
- R5: Before a bank counter is used, it is raised to the current part's first lane index (0 or 16) if it is below that index.
- R6: When `in_bcast_limit` is 1, an access that gains its second lane is moved to order 32+k. k starts at 0 for each instruction and counts such accesses in lane order.
- R7: When `in_bcast_limit` is 0, a merged access keeps the order its bank counter gave it, so every order is below 32.
- R8: Beats leave in ascending order. Accesses with the same order leave in creation order, which is the order of their lowest lane. `out_last` is 1 on the final beat only.
- R9: Inactive lanes are ignored. An instruction with no active lane produces no beats, and `in_ready` returns to 1.
- R10: `out_norders` equals the number of distinct order values in the list. It is the same on every beat of one instruction.
- R11: While `out_valid` is 1 and `out_ready` is 0, the beat stays valid and its fields do not change.
- R12: After reset, `in_ready` is 1 and `out_valid` is 0. `in_ready` is 1 only while no instruction is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The block can take an instruction |
| in_addr | input | 1024 | Lane byte addresses, lane i at bits [32i+31:32i] |
| in_active | input | 32 | Active lane mask |
| in_bcast_limit | input | 1 | Gives each broadcast its own slot |
| out_valid | output | 1 | An access beat is offered |
| out_ready | input | 1 | The consumer takes the beat |
| out_addr | output | 32 | Access address |
| out_order | output | 6 | Issue slot of the access |
| out_lanes | output | 32 | Lanes served by the access |
| out_last | output | 1 | Final beat of the instruction |
| out_norders | output | 7 | Distinct slot count of the instruction |

## Verification
Some properties are checked by assertions on every cycle:
- a held beat stays stable under backpressure;
- orders never decrease from one beat to the next;
- limited broadcasts sit at order 32 or above, and with no limit every order stays below 32;
- lane masks are non-empty and contain only active lanes;
- a lane matches at most one access in its part;
- a bank counter stays below the warp size;
- `in_ready` falls once an instruction is taken.

Other behaviour can only be shown by the bench's scenarios, each compared beat by beat against a behavioural model:
- the exact slot numbers that come from bank collisions and from raising counters to the part start;
- the broadcast numbering;
- the stable tie order;
- the distinct slot count;
- the empty-mask case.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUILD = 2'd1,
    ST_COUNT = 2'd2,
    ST_EMIT  = 2'd3
  } sbs_state_e;
endpackage

// File: rtl/sbs_bank_ctr.sv
module sbs_bank_ctr #(
  parameter int WARP   = 32,
  parameter int BANKS  = 16,
  parameter int ORD_W  = 6,
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              upd,
  input  logic [BANK_W-1:0] bank,
  input  logic [ORD_W-1:0]  floor_ord,
  output logic [ORD_W-1:0]  ord
);
  logic [ORD_W-1:0] cnt [BANKS];
  logic [ORD_W-1:0] cur;

  assign cur = cnt[bank];
  assign ord = (cur < floor_ord) ? floor_ord : cur;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int b = 0; b < BANKS; b++) cnt[b] <= '0;
    end else if (upd) begin
      cnt[bank] <= ord + ORD_W'(1);
    end
  end

  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    upd |-> ord < ORD_W'(WARP));
endmodule

// File: rtl/sbs_match.sv
module sbs_match #(
  parameter int NENT   = 32,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 6,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] ent_addr [NENT],
  input  logic [CNT_W-1:0]  lo,
  input  logic [CNT_W-1:0]  hi,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);
  logic [NENT-1:0] hitv;

  always_comb begin
    for (int i = 0; i < NENT; i++)
      hitv[i] = (CNT_W'(i) >= lo) && (CNT_W'(i) < hi) && (ent_addr[i] == addr);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = NENT - 1; i >= 0; i--)
      if (hitv[i]) hit_idx = IDX_W'(i);
  end

  assign hit = |hitv;

  // R2
  uniq_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hitv));
endmodule

// File: rtl/sbs_pick.sv
module sbs_pick #(
  parameter int NENT  = 32,
  parameter int ORD_W = 6,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NENT-1:0]  pend,
  input  logic [ORD_W-1:0] ords [NENT],
  output logic             any,
  output logic [IDX_W-1:0] sel
);
  logic [ORD_W-1:0] best;

  always_comb begin
    any  = 1'b0;
    sel  = '0;
    best = '1;
    for (int i = 0; i < NENT; i++) begin
      if (pend[i] && (!any || ords[i] < best)) begin
        any  = 1'b1;
        sel  = IDX_W'(i);
        best = ords[i];
      end
    end
  end

  // R8
  pick_pending_chk: assert property (@(posedge clk) disable iff (rst)
    any |-> pend[sel]);
endmodule

// File: rtl/sbs_sched.sv
module sbs_sched
  import sbs_pkg::*;
#(
  parameter int WARP       = 32,
  parameter int ADDR_W     = 32,
  parameter int BANKS      = 16,
  parameter int WORD_BYTES = 4,
  parameter int PARTS      = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [WARP*ADDR_W-1:0]      in_addr,
  input  logic [WARP-1:0]             in_active,
  input  logic                        in_bcast_limit,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [ADDR_W-1:0]           out_addr,
  output logic [$clog2(2*WARP)-1:0]   out_order,
  output logic [WARP-1:0]             out_lanes,
  output logic                        out_last,
  output logic [$clog2(2*WARP+1)-1:0] out_norders
);
  localparam int ORD_W    = $clog2(2 * WARP);
  localparam int NORD_W   = $clog2(2 * WARP + 1);
  localparam int CNT_W    = $clog2(WARP + 1);
  localparam int IDX_W    = $clog2(WARP);
  localparam int BANK_W   = $clog2(BANKS);
  localparam int BSH      = $clog2(WORD_BYTES);
  localparam int PART_LEN = WARP / PARTS;
  localparam int NSLOT    = 2 * WARP;

  sbs_state_e state_q;

  logic [ADDR_W-1:0] a_q [WARP];
  logic [WARP-1:0]   act_q;
  logic              lim_q;
  logic [IDX_W-1:0]  lane_q;
  logic [CNT_W-1:0]  cnt_q, qpb_q, rem_q;
  logic [ORD_W-1:0]  bcnt_q;

  logic [ADDR_W-1:0] e_addr [WARP];
  logic [ORD_W-1:0]  e_ord  [WARP];
  logic [WARP-1:0]   e_mask [WARP];
  logic [WARP-1:0]   e_bc;
  logic [WARP-1:0]   emitted;

  logic              accept, building, lane_on, first_of_part;
  logic [ADDR_W-1:0] lane_addr;
  logic [BANK_W-1:0] lane_bank;
  logic [ORD_W-1:0]  part_start, new_ord;
  logic [CNT_W-1:0]  qpb;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [WARP-1:0]   lane_bit, pend;
  logic              pick_any;
  logic [IDX_W-1:0]  pick_sel;
  logic [NSLOT-1:0]  seen;
  logic [NORD_W-1:0] nord_n;
  logic              load_slot;

  assign in_ready      = (state_q == ST_IDLE);
  assign accept        = in_valid && in_ready;
  assign building      = (state_q == ST_BUILD);
  assign lane_addr     = a_q[lane_q];
  assign lane_on       = act_q[lane_q];
  assign lane_bank     = lane_addr[BSH +: BANK_W];
  assign part_start    = ORD_W'(lane_q) & ~ORD_W'(PART_LEN - 1);
  assign first_of_part = ((ORD_W'(lane_q) & ORD_W'(PART_LEN - 1)) == '0);
  assign qpb           = first_of_part ? cnt_q : qpb_q;
  assign lane_bit      = WARP'(1) << lane_q;

  sbs_match #(.NENT(WARP), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_match (
    .clk(clk), .rst(rst), .addr(lane_addr), .ent_addr(e_addr),
    .lo(qpb), .hi(cnt_q), .hit(hit), .hit_idx(hit_idx)
  );

  sbs_bank_ctr #(.WARP(WARP), .BANKS(BANKS), .ORD_W(ORD_W), .BANK_W(BANK_W)) u_ctr (
    .clk(clk), .rst(rst), .clr(accept), .upd(building && lane_on && !hit),
    .bank(lane_bank), .floor_ord(part_start), .ord(new_ord)
  );

  always_comb begin
    for (int i = 0; i < WARP; i++)
      pend[i] = (CNT_W'(i) < cnt_q) && !emitted[i];
  end

  sbs_pick #(.NENT(WARP), .ORD_W(ORD_W), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst(rst), .pend(pend), .ords(e_ord), .any(pick_any), .sel(pick_sel)
  );

  always_comb begin
    seen = '0;
    for (int i = 0; i < WARP; i++)
      if (CNT_W'(i) < cnt_q) seen[e_ord[i]] = 1'b1;
    nord_n = '0;
    for (int j = 0; j < NSLOT; j++)
      nord_n = nord_n + NORD_W'(seen[j]);
  end

  assign load_slot = (state_q == ST_EMIT) && (!out_valid || out_ready);

  // Access table: written one lane per cycle during the build phase.
  always_ff @(posedge clk) begin
    if (building && lane_on) begin
      if (hit) begin
        e_mask[hit_idx] <= e_mask[hit_idx] | lane_bit;
        if (lim_q && !e_bc[hit_idx])
          e_ord[hit_idx] <= ORD_W'(WARP) + bcnt_q;
      end else begin
        e_addr[cnt_q[IDX_W-1:0]] <= lane_addr;
        e_ord[cnt_q[IDX_W-1:0]]  <= new_ord;
        e_mask[cnt_q[IDX_W-1:0]] <= lane_bit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int i = 0; i < WARP; i++) a_q[i] <= in_addr[i*ADDR_W +: ADDR_W];
      act_q <= in_active;
      lim_q <= in_bcast_limit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      lane_q      <= '0;
      cnt_q       <= '0;
      qpb_q       <= '0;
      rem_q       <= '0;
      bcnt_q      <= '0;
      e_bc        <= '0;
      emitted     <= '0;
      out_valid   <= 1'b0;
      out_addr    <= '0;
      out_order   <= '0;
      out_lanes   <= '0;
      out_last    <= 1'b0;
      out_norders <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_BUILD;
            lane_q  <= '0;
            cnt_q   <= '0;
            qpb_q   <= '0;
            bcnt_q  <= '0;
            e_bc    <= '0;
            emitted <= '0;
          end
        end
        ST_BUILD: begin
          qpb_q <= qpb;
          if (lane_on) begin
            if (hit) begin
              if (lim_q && !e_bc[hit_idx]) begin
                e_bc[hit_idx] <= 1'b1;
                bcnt_q        <= bcnt_q + ORD_W'(1);
              end
            end else begin
              e_bc[cnt_q[IDX_W-1:0]] <= 1'b0;
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          lane_q <= lane_q + IDX_W'(1);
          if (lane_q == IDX_W'(WARP - 1)) state_q <= ST_COUNT;
        end
        ST_COUNT: begin
          out_norders <= nord_n;
          rem_q       <= cnt_q;
          state_q     <= (cnt_q == '0) ? ST_IDLE : ST_EMIT;
        end
        ST_EMIT: begin
          if (load_slot) begin
            if (pick_any) begin
              out_valid         <= 1'b1;
              out_addr          <= e_addr[pick_sel];
              out_order         <= e_ord[pick_sel];
              out_lanes         <= e_mask[pick_sel];
              out_last          <= (rem_q == CNT_W'(1));
              emitted[pick_sel] <= 1'b1;
              rem_q             <= rem_q - CNT_W'(1);
            end else begin
              out_valid <= 1'b0;
              out_last  <= 1'b0;
              state_q   <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_order)
      && $stable(out_lanes) && $stable(out_last));

  // R8
  sorted_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !out_last |=> out_valid && (out_order >= $past(out_order)));

  // R6
  bcast_slot_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && lim_q && ($countones(out_lanes) > 1) |-> out_order >= ORD_W'(WARP));

  // R7
  no_limit_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !lim_q |-> out_order < ORD_W'(WARP));

  // R9
  lanes_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_lanes != '0) && ((out_lanes & ~act_q) == '0));

  // R12
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> !in_ready);
endmodule

// File: tb/tb_sbs_sched.sv
module tb_sbs_sched;
  localparam int W  = 32;
  localparam int PL = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid, in_ready, in_bcast_limit;
  logic [W*32-1:0] in_addr;
  logic [W-1:0]  in_active;
  logic          out_valid, out_ready, out_last;
  logic [31:0]   out_addr;
  logic [5:0]    out_order;
  logic [W-1:0]  out_lanes;
  logic [6:0]    out_norders;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] A [W];
  logic [W-1:0] M;

  logic [31:0]  m_addr [W];
  int           m_ord  [W];
  logic [W-1:0] m_mask [W];
  int           m_n, m_nord;

  always #10 clk = ~clk;

  sbs_sched dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_active(in_active), .in_bcast_limit(in_bcast_limit),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_order(out_order), .out_lanes(out_lanes), .out_last(out_last),
    .out_norders(out_norders)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model(input bit lim);
    int cnt [16];
    bit isb [W];
    int bc, qpb, ps, bk, hitj;
    m_n = 0; bc = 0; qpb = 0;
    for (int b = 0; b < 16; b++) cnt[b] = 0;
    for (int l = 0; l < W; l++) begin
      if (l % PL == 0) qpb = m_n;
      if (!M[l]) continue;
      hitj = -1;
      for (int j = qpb; j < m_n; j++) if (m_addr[j] == A[l]) hitj = j;
      if (hitj >= 0) begin
        m_mask[hitj][l] = 1'b1;
        if (lim && !isb[hitj]) begin
          isb[hitj] = 1'b1; m_ord[hitj] = W + bc; bc++;
        end
      end else begin
        ps = (l / PL) * PL;
        bk = int'((A[l] >> 2) % 16);
        if (cnt[bk] < ps) cnt[bk] = ps;
        m_addr[m_n] = A[l]; m_ord[m_n] = cnt[bk]; m_mask[m_n] = '0;
        m_mask[m_n][l] = 1'b1; isb[m_n] = 1'b0;
        cnt[bk]++; m_n++;
      end
    end
    for (int i = 1; i < m_n; i++) begin
      for (int j = i; j > 0 && m_ord[j-1] > m_ord[j]; j--) begin
        logic [31:0] ta; int to; logic [W-1:0] tm;
        ta = m_addr[j]; m_addr[j] = m_addr[j-1]; m_addr[j-1] = ta;
        to = m_ord[j];  m_ord[j]  = m_ord[j-1];  m_ord[j-1]  = to;
        tm = m_mask[j]; m_mask[j] = m_mask[j-1]; m_mask[j-1] = tm;
      end
    end
    m_nord = 0;
    for (int i = 0; i < m_n; i++) if (i == 0 || m_ord[i] != m_ord[i-1]) m_nord++;
  endtask

  task automatic run_case(input bit lim, input bit bp, input string req);
    int k;
    bit held;
    logic [31:0] h_addr; logic [5:0] h_ord; logic [W-1:0] h_lanes;
    bit rdy;
    model(lim);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    for (int i = 0; i < W; i++) in_addr[i*32 +: 32] = A[i];
    in_active = M; in_bcast_limit = lim; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(!in_ready, "R12", "in_ready after accept", in_ready, 0);
    k = 0; held = 1'b0;
    while (!in_ready) begin
      if (held) chk(out_valid && out_addr == h_addr && out_order == h_ord
                    && out_lanes == h_lanes, "R11", "held beat", out_order, h_ord);
      rdy = bp ? 1'($urandom % 2) : 1'b1;
      out_ready = rdy;
      if (out_valid && rdy) begin
        if (k >= m_n) chk(0, req, "extra beat", k, m_n);
        else begin
          chk(out_addr == m_addr[k], req, $sformatf("beat %0d addr", k), out_addr, m_addr[k]);
          chk(out_order == 6'(m_ord[k]), {req, "/R8"}, $sformatf("beat %0d order", k), out_order, m_ord[k]);
          chk(out_lanes == m_mask[k], {req, "/R2"}, $sformatf("beat %0d lanes", k), out_lanes, m_mask[k]);
          chk(out_last == (k == m_n - 1), "R8", $sformatf("beat %0d last", k), out_last, k == m_n - 1);
          chk(out_norders == 7'(m_nord), "R10", "distinct orders", out_norders, m_nord);
        end
        k++;
      end
      held = out_valid && !rdy;
      h_addr = out_addr; h_ord = out_order; h_lanes = out_lanes;
      @(negedge clk);
    end
    chk(k == m_n, {req, "/R9"}, "beat count", k, m_n);
    chk(!out_valid, "R12", "idle out_valid", out_valid, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL R12 watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_addr = '0; in_active = '0;
    in_bcast_limit = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready && !out_valid, "R12", "reset state", {in_ready, out_valid}, 2'b10);

    // R1 R4 R5: consecutive words, distinct banks per part, part 1 raised to 16
    M = '1;
    for (int i = 0; i < W; i++) A[i] = 32'(i * 4);
    run_case(1'b0, 1'b0, "R5");
    // R1 R4: 64-byte stride, every lane on bank 0
    for (int i = 0; i < W; i++) A[i] = 32'(i * 64);
    run_case(1'b0, 1'b1, "R4");
    // R2 R3 R6: one address for all lanes, limit on
    for (int i = 0; i < W; i++) A[i] = 32'h100;
    run_case(1'b1, 1'b0, "R6");
    // R3 R7: same, limit off
    run_case(1'b0, 1'b1, "R7");
    // R9: no active lane
    M = '0;
    run_case(1'b1, 1'b0, "R9");
    // R9: alternating lanes, bank conflicts
    M = 32'h5555_5555;
    for (int i = 0; i < W; i++) A[i] = 32'(i * 64);
    run_case(1'b0, 1'b0, "R9");
    // R1: byte offsets in one word are distinct addresses on one bank
    M = '1;
    for (int i = 0; i < W; i++) A[i] = 32'((i % 4) + 64 * (i % 3));
    run_case(1'b1, 1'b1, "R1");
    // Random mixes
    for (int t = 0; t < 24; t++) begin
      M = $urandom;
      for (int i = 0; i < W; i++) A[i] = 32'(($urandom % 12) * 4 + 64 * ($urandom % 3));
      run_case(1'($urandom % 2), 1'($urandom % 2), (t % 2) ? "R6" : "R4");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule